// File: doc/BRIEF.md
# Instruction Fetch Address Mapper

This block turns a word-addressed program counter into a physical fetch target. The byte fetch address is the program counter shifted left by two. Its top bit picks one of two instruction map registers. The picked map register then steers the fetch either to the internal instruction memory or to one 128 KB segment of unified memory. A fetch into a unified segment that is not present is flagged as a bus error. The fetch is then dropped.

The two map registers live inside the block and come out of reset with fixed defaults. After that they take the values on the map inputs on every clock, so a fetch is translated with the map values presented one cycle earlier. Results are registered and appear one cycle after the fetch request. The memories themselves and the path for the fetched data sit outside this block.

Top module: `ifm_fetch_mapper`

## Requirements
- R1: While reset is asserted the outputs are target 0 (none), error 0, segment 0 and offset 0.
- R2: In a cycle with no fetch request the next cycle shows target 0 (none) and error 0.
- R3: The byte address is the 16-bit PC followed by two zero bits (18 bits). A fetch that resolves to internal memory shows target 1 and segment 0, with the full 18-bit byte address as offset. The result appears on the clock edge that samples the request.
- R4: Byte address bit 17 (PC bit 15) selects map register 1 when set and map register 0 when clear.
- R5: Bit 12 of the selected map register picks internal memory (1) or unified memory (0). Unified fetches report segment = map bits 7:0, and all other map bits are ignored.
- R6: A unified fetch shows target 2 with offset = byte address bits 16:0 and offset bit 17 forced to 0.
- R7: A unified fetch whose segment bit in the 256-bit present bitmap is 0 shows error 1 and target 0 (none). The segment and offset are still reported.
- R8: Map register 0 resets to 0x0000 and map register 1 to 0x007F. A fetch of PC 0xFFC0 on the first active cycle therefore goes to unified segment 0x7F at offset 0x1FF00.
- R9: The map registers capture the map inputs on every active clock edge. A fetch uses the map values driven in the previous cycle, so a map change in the same cycle as a fetch does not affect that fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req_i | input | 1 | Fetch request for this cycle |
| pc_i | input | 16 | Word program counter |
| map0_i | input | 16 | New value for map register 0 |
| map1_i | input | 16 | New value for map register 1 |
| seg_present_i | input | 256 | One bit per unified segment, 1 = present |
| fetch_tgt_o | output | 2 | 0 none, 1 internal memory, 2 unified memory |
| fetch_seg_o | output | 8 | Unified segment number |
| fetch_off_o | output | 18 | Byte offset within the target |
| fetch_err_o | output | 1 | Bus error: unified segment not present |

## Verification
A map register update and a fetch translation fall in the same cycle whenever the map inputs change while a fetch is requested. The sweep changes both map inputs on every cycle while it also issues fetches. The expected result is always computed from the map values of the previous cycle. The first fetch after reset is set up with map inputs that differ from the reset defaults. This exposes whether the defaults or the incoming values steered it, and the fetch after it confirms the capture.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_IMEM = 2'd1,
    TGT_UMEM = 2'd2
  } ifm_tgt_e;
endpackage

// File: rtl/ifm_rst_sync.sv
module ifm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ifm_map_regs.sv
module ifm_map_regs #(
  parameter int          MAP_W    = 16,
  parameter logic [15:0] MAP0_RST = 16'h0000,
  parameter logic [15:0] MAP1_RST = 16'h007F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAP_W-1:0] map0_i,
  input  logic [MAP_W-1:0] map1_i,
  output logic [MAP_W-1:0] map0_q,
  output logic [MAP_W-1:0] map1_q
);
  localparam int NMAP = 2;

  logic [MAP_W-1:0] map_in  [NMAP];
  logic [MAP_W-1:0] map_reg [NMAP];

  assign map_in[0] = map0_i;
  assign map_in[1] = map1_i;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    localparam logic [MAP_W-1:0] RST_VAL = (g == 0) ? MAP_W'(MAP0_RST) : MAP_W'(MAP1_RST);
    logic [MAP_W-1:0] map_d;

    always_comb begin
      map_d = map_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_reg[g] <= RST_VAL;
      else        map_reg[g] <= map_d;
    end
  end

  assign map0_q = map_reg[0];
  assign map1_q = map_reg[1];
endmodule

// File: rtl/ifm_decode.sv
module ifm_decode
  import ifm_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int MAP_W       = 16,
  parameter int SEG_W       = 8,
  parameter int UMEM_AW     = 17,
  parameter int MEM_SEL_BIT = 12
) (
  input  logic [PC_W-1:0]       pc_i,
  input  logic [MAP_W-1:0]      map0_q,
  input  logic [MAP_W-1:0]      map1_q,
  input  logic [(1<<SEG_W)-1:0] seg_present_i,
  output ifm_tgt_e              dec_tgt,
  output logic [SEG_W-1:0]      dec_seg,
  output logic [PC_W+1:0]       dec_off,
  output logic                  dec_err
);
  localparam int BA_W    = PC_W + 2;
  localparam int SEL_BIT = BA_W - 1;

  logic [BA_W-1:0]  byte_addr;
  logic [MAP_W-1:0] sel_map;
  logic [SEG_W-1:0] map_seg;
  logic             seg_hit;
  logic             map_unused;

  assign byte_addr  = {pc_i, 2'b00};
  assign sel_map    = byte_addr[SEL_BIT] ? map1_q : map0_q;
  assign map_seg    = sel_map[SEG_W-1:0];
  assign seg_hit    = seg_present_i[map_seg];
  assign map_unused = ^sel_map;

  always_comb begin
    dec_tgt = TGT_NONE;
    dec_seg = '0;
    dec_off = byte_addr;
    dec_err = 1'b0;
    if (sel_map[MEM_SEL_BIT]) begin
      dec_tgt = TGT_IMEM;
    end else begin
      dec_seg = map_seg;
      dec_off = BA_W'(byte_addr[UMEM_AW-1:0]);
      if (seg_hit) dec_tgt = TGT_UMEM;
      else         dec_err = 1'b1;
    end
  end
endmodule

// File: rtl/ifm_out_reg.sv
module ifm_out_reg
  import ifm_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req_i,
  input  ifm_tgt_e         dec_tgt,
  input  logic [SEG_W-1:0] dec_seg,
  input  logic [OFF_W-1:0] dec_off,
  input  logic             dec_err,
  output ifm_tgt_e         tgt_q,
  output logic [SEG_W-1:0] seg_q,
  output logic [OFF_W-1:0] off_q,
  output logic             err_q
);
  ifm_tgt_e         tgt_d;
  logic             err_d;
  logic             addr_en;

  always_comb begin
    addr_en = fetch_req_i;
    tgt_d   = fetch_req_i ? dec_tgt : TGT_NONE;
    err_d   = fetch_req_i & dec_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_NONE;
      err_q <= 1'b0;
    end else begin
      tgt_q <= tgt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      off_q <= '0;
    end else if (addr_en) begin
      seg_q <= dec_seg;
      off_q <= dec_off;
    end
  end
endmodule

// File: rtl/ifm_fetch_mapper.sv
module ifm_fetch_mapper
  import ifm_pkg::*;
#(
  parameter int          PC_W        = 16,
  parameter int          MAP_W       = 16,
  parameter int          SEG_W       = 8,
  parameter int          UMEM_AW     = 17,
  parameter int          MEM_SEL_BIT = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MAP0_RST    = 16'h0000,
  parameter logic [15:0] MAP1_RST    = 16'h007F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_req_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [MAP_W-1:0]      map0_i,
  input  logic [MAP_W-1:0]      map1_i,
  input  logic [(1<<SEG_W)-1:0] seg_present_i,
  output logic [1:0]            fetch_tgt_o,
  output logic [SEG_W-1:0]      fetch_seg_o,
  output logic [PC_W+1:0]       fetch_off_o,
  output logic                  fetch_err_o
);
  localparam int OFF_W = PC_W + 2;

  logic             rst_sync_n;
  logic [MAP_W-1:0] map0_q, map1_q;
  ifm_tgt_e         dec_tgt, tgt_q;
  logic [SEG_W-1:0] dec_seg;
  logic [OFF_W-1:0] dec_off;
  logic             dec_err;

  ifm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ifm_map_regs #(.MAP_W(MAP_W), .MAP0_RST(MAP0_RST), .MAP1_RST(MAP1_RST)) u_map_regs (
    .clk(clk), .rst_n(rst_sync_n), .map0_i(map0_i), .map1_i(map1_i),
    .map0_q(map0_q), .map1_q(map1_q)
  );

  ifm_decode #(.PC_W(PC_W), .MAP_W(MAP_W), .SEG_W(SEG_W), .UMEM_AW(UMEM_AW),
               .MEM_SEL_BIT(MEM_SEL_BIT)) u_decode (
    .pc_i(pc_i), .map0_q(map0_q), .map1_q(map1_q), .seg_present_i(seg_present_i),
    .dec_tgt(dec_tgt), .dec_seg(dec_seg), .dec_off(dec_off), .dec_err(dec_err)
  );

  ifm_out_reg #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_out_reg (
    .clk(clk), .rst_n(rst_sync_n), .fetch_req_i(fetch_req_i),
    .dec_tgt(dec_tgt), .dec_seg(dec_seg), .dec_off(dec_off), .dec_err(dec_err),
    .tgt_q(tgt_q), .seg_q(fetch_seg_o), .off_q(fetch_off_o), .err_q(fetch_err_o)
  );

  assign fetch_tgt_o = tgt_q;
endmodule

// File: rtl/ifm_fetch_mapper_chk.sv
module ifm_fetch_mapper_chk #(
  parameter int SEG_W = 8,
  parameter int OFF_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req_i,
  input logic [1:0]       fetch_tgt_o,
  input logic [SEG_W-1:0] fetch_seg_o,
  input logic [OFF_W-1:0] fetch_off_o,
  input logic             fetch_err_o
);
  a_r7_error_means_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err_o |-> fetch_tgt_o == 2'd0);

  a_r2_idle_gives_none: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req_i |=> (fetch_tgt_o == 2'd0 && !fetch_err_o));

  a_r6_unified_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tgt_o == 2'd2 |-> !fetch_off_o[OFF_W-1]);

  a_r5_internal_no_segment: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tgt_o == 2'd1 |-> fetch_seg_o == '0);

  a_r3_offset_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tgt_o != 2'd0 |-> fetch_off_o[1:0] == 2'b00);

  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_tgt_o != 2'd3);
endmodule

bind ifm_fetch_mapper ifm_fetch_mapper_chk #(.SEG_W(SEG_W), .OFF_W(PC_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req_i(fetch_req_i), .fetch_tgt_o(fetch_tgt_o),
  .fetch_seg_o(fetch_seg_o), .fetch_off_o(fetch_off_o), .fetch_err_o(fetch_err_o)
);

// File: tb/test_ifm_fetch_mapper.sv
`timescale 1ns/1ps
module test_ifm_fetch_mapper;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fetch_req_i;
  logic [15:0]  pc_i, map0_i, map1_i;
  logic [255:0] seg_present_i;
  logic [1:0]   fetch_tgt_o;
  logic [7:0]   fetch_seg_o;
  logic [17:0]  fetch_off_o;
  logic         fetch_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ifm_fetch_mapper i_ifm_fetch_mapper (
    .clk(clk), .rst_n(rst_n), .fetch_req_i(fetch_req_i), .pc_i(pc_i),
    .map0_i(map0_i), .map1_i(map1_i), .seg_present_i(seg_present_i),
    .fetch_tgt_o(fetch_tgt_o), .fetch_seg_o(fetch_seg_o),
    .fetch_off_o(fetch_off_o), .fetch_err_o(fetch_err_o)
  );

  task automatic check(input string tag, input bit full, input logic [1:0] et,
                       input logic ee, input logic [7:0] es, input logic [17:0] eo);
    bit bad;
    checks++;
    bad = (fetch_tgt_o !== et) || (fetch_err_o !== ee);
    if (full) bad = bad || (fetch_seg_o !== es) || (fetch_off_o !== eo);
    if (bad) begin
      errors++;
      $display("FAIL %s: tgt=%0d err=%0d seg=%h off=%h expected tgt=%0d err=%0d seg=%h off=%h",
               tag, fetch_tgt_o, fetch_err_o, fetch_seg_o, fetch_off_o, et, ee, es, eo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: tgt=%0d expected run to complete", fetch_tgt_o);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0]  prev0, prev1;
    logic [17:0]  ba, eo;
    logic [15:0]  m;
    logic [7:0]   es;
    logic [1:0]   et;
    logic         ee, ereq, pend;
    string        tag;

    rst_n = 1'b0; fetch_req_i = 1'b1; pc_i = 16'hFFC0;
    map0_i = 16'h1000; map1_i = 16'h1000;
    seg_present_i = '1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b1, 2'd0, 1'b0, 8'h00, 18'h0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (fetch_tgt_o != 2'd0) break;
    end
    // R8: first fetch uses reset map defaults (map1 = 0x7F unified)
    check("R8 reset map defaults", 1'b1, 2'd2, 1'b0, 8'h7F, 18'h1FF00);
    @(negedge clk);
    // R9: the next fetch uses the captured 0x1000 values -> internal memory
    check("R9 captured map used", 1'b1, 2'd1, 1'b0, 8'h00, 18'h3FF00);
    prev0 = 16'h1000; prev1 = 16'h1000;
    pend = 1'b0; et = 0; ee = 0; es = 0; eo = 0; ereq = 0; tag = "";

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pend) check(tag, ereq, et, ee, es, eo);
      for (int s = 0; s < 256; s++)
        seg_present_i[s] = (i < 1500) ? ((s % 5) != 2) : ((s % 5) == 2);
      case (i % 8)
        0: pc_i = 16'h0000;
        1: pc_i = 16'hFFFF;
        2: pc_i = 16'h7FFF;
        3: pc_i = 16'h8000;
        default: pc_i = 16'((i * 2741 + 16'hFFC0) & 16'hFFFF);
      endcase
      fetch_req_i = (i % 7) != 6;
      map0_i = 16'(((i * 37) & 8'hFF) | (((i / 8) & 1) != 0 ? 16'h1000 : 16'h0)
                   | (((i / 32) & 1) != 0 ? 16'hE300 : 16'h0));
      map1_i = 16'(((i * 91 + 5) & 8'hFF) | (((i / 16) & 1) != 0 ? 16'h1000 : 16'h0)
                   | (((i / 64) & 1) != 0 ? 16'h0C00 : 16'h0));
      ba = {pc_i, 2'b00};
      m  = ba[17] ? prev1 : prev0;   // R4 map selection
      ereq = fetch_req_i;
      if (!fetch_req_i) begin
        et = 2'd0; ee = 1'b0; es = 8'h0; eo = 18'h0; tag = "R2 idle";
      end else if (m[12]) begin
        et = 2'd1; ee = 1'b0; es = 8'h0; eo = ba;
        tag = ba[17] ? "R4 R3 internal via map1" : "R3 internal via map0";
      end else begin
        es = m[7:0]; eo = {1'b0, ba[16:0]};
        if (seg_present_i[es]) begin
          et = 2'd2; ee = 1'b0;
          tag = ba[17] ? "R4 R5 R6 unified via map1" : "R5 R6 unified via map0";
        end else begin
          et = 2'd0; ee = 1'b1; tag = "R7 absent segment";
        end
      end
      prev0 = map0_i; prev1 = map1_i;   // R9: captured this edge, used next fetch
      pend = 1'b1;
    end
    @(negedge clk);
    check(tag, ereq, et, ee, es, eo);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule